// File: doc/BRIEF.md
# SPI Master Byte Shift Engine

This block is the serial core of a byte-wide SPI master. It takes 8-bit words from an external transmit queue over a ready/valid pull interface and shifts each one out on the serial data output, most significant bit first. At the same time it assembles the bits seen on the serial data input into a byte and hands that byte to an external receive queue with a one-cycle push strobe. The serial clock is the reference clock divided by a power of two picked by a 3-bit divisor code, and any of the four polarity/phase combinations can be chosen.

Software drives the block through one configuration word. The word holds an enable bit, polarity and phase bits, the divisor code and a manual-start control. Clock and mode settings are taken into the engine only when the enable bit goes from 0 to 1. Rewriting them while the engine is running never disturbs the serial clock. In manual-start mode, queued words stay in the transmit queue until software writes the trigger bit.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset the serial clock output is low, busy is low, no receive push and no transmit pull occur, and the captured settings are mode 0 with divisor code 1.
- R2: The divisor code in configuration bits 5:3 sets the serial clock half period to 2^N reference cycles, so the full period is ref/(2<<N). A code of 0 is captured as 1.
- R3: Configuration bit 0 is the enable, bit 1 the clock polarity and bit 2 the clock phase. While the engine is idle or disabled, the serial clock rests at the captured polarity level.
- R4: Polarity, phase and divisor are captured only in the cycle the enable bit rises. Changing them while the engine is enabled does not affect the serial clock level or its timing.
- R5: With phase 0, the data output carries bit 7 before the first clock edge. The input is sampled on each leading edge, and the output advances on each trailing edge.
- R6: With phase 1, the data output advances on each leading edge and the input is sampled on each trailing edge, most significant bit first.
- R7: Every word takes exactly 16 serial clock edges. The received byte is pushed with a single-cycle receive strobe after the last edge of the word.
- R8: A new word is pulled only once the previous word's 16 edges are done. When the queue is not empty, words follow one another with no gap, the first edge of the next word coming one half period after the last edge of the current one.
- R9: When configuration bit 15 is set, no word is pulled until bit 16 is written as 1 (a one-cycle pulse). That trigger stays armed until the transmit queue runs empty at the end of a word.
- R10: Busy rises on the first serial clock edge of a burst and stays high until the final edge of the last queued word. It is low whenever the engine is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 17 | Configuration word: enable, polarity, phase, divisor, manual enable, trigger |
| tx_data_i | input | 8 | Head word of the transmit queue |
| tx_valid_i | input | 1 | Transmit queue is not empty |
| tx_ready_o | output | 1 | Pull strobe: head word taken this cycle |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Receive push strobe, one cycle per byte |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| busy_o | output | 1 | Transfer in progress |

## Verification
A wrong edge counter shows up as misframed bytes. The slave model on the bench then sees a shifted output byte at the sixteenth edge, and the receive strobe comes one edge early or late, both within one word. A bad divisor count or a wrong captured setting changes the gap between serial clock edges, and this shows at the second edge of the next word. A capture at the wrong time shows as an idle level or half period that differs from the one set at the last enable rise. A wrong manual-start arm state shows as a pull during the long hold window, or as a queue left undrained after the trigger.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int DIV_W = 3;

    // configuration word bit positions decoded by the register block
    localparam int CFG_W      = 17;
    localparam int CB_EN      = 0;
    localparam int CB_CPOL    = 1;
    localparam int CB_CPHA    = 2;
    localparam int CB_DIV_LO  = 3;
    localparam int CB_MAN_EN  = 15;
    localparam int CB_TRIG    = 16;

    typedef enum logic {
        ST_IDLE,
        ST_SHIFT
    } eng_state_e;

    typedef struct packed {
        logic             cpol;
        logic             cpha;
        logic [DIV_W-1:0] div;
    } mode_t;

endpackage

// File: rtl/spi_cfg_latch.sv
module spi_cfg_latch
    import spi_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             cpol_i,
    input  logic             cpha_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             en_o,
    output mode_t            mode_o
);

    typedef struct packed {
        logic  en;
        mode_t mode;
    } latch_t;

    latch_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.en = en_i;
        // capture only on the disable-to-enable transition
        if (en_i && !r_q.en) begin
            r_d.mode.cpol = cpol_i;
            r_d.mode.cpha = cpha_i;
            r_d.mode.div  = (div_i == '0) ? DIV_W'(1) : div_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.en        <= 1'b0;
            r_q.mode.cpol <= 1'b0;
            r_q.mode.cpha <= 1'b0;
            r_q.mode.div  <= DIV_W'(1);
        end else begin
            r_q <= r_d;
        end
    end

    assign en_o   = r_q.en;
    assign mode_o = r_q.mode;

endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div
    import spi_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    localparam int CNT_W = 1 << DIV_W;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        half_m1 = (CNT_W'(1) << div_i) - CNT_W'(1);
        tick_o  = run_i && (cnt_q == half_m1);
        if (!run_i || restart_i || tick_o)
            cnt_d = '0;
        else
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_eng_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  mode_t             mode_i,
    input  logic              tick_i,
    input  logic              man_en_i,
    input  logic              trig_i,
    input  logic [WORD_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              busy_o,
    output logic              run_o,
    output logic              restart_o,
    output logic              armed_o
);

    localparam int EDGES  = 2 * WORD_W;
    localparam int EDGE_W = $clog2(EDGES);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

    typedef struct packed {
        eng_state_e        st;
        logic              sclk;
        logic              mosi;
        logic              busy;
        logic              armed;
        logic [EDGE_W-1:0] edge_n;
        logic [WORD_W-1:0] tx_sr;
        logic [WORD_W-1:0] rx_sr;
        logic [WORD_W-1:0] rx_data;
        logic              rx_valid;
    } shf_t;

    shf_t s_d, s_q;

    logic              can_go;
    logic              lead;
    logic              sample;
    logic [WORD_W-1:0] rx_next;

    always_comb begin
        s_d          = s_q;
        s_d.rx_valid = 1'b0;
        tx_ready_o   = 1'b0;
        restart_o    = 1'b0;
        lead         = ~s_q.edge_n[0];
        sample       = lead ^ mode_i.cpha;
        rx_next      = sample ? {s_q.rx_sr[WORD_W-2:0], miso_i} : s_q.rx_sr;

        if (man_en_i && trig_i)
            s_d.armed = 1'b1;
        can_go = tx_valid_i && (!man_en_i || s_q.armed);

        if (!en_i) begin
            s_d.st    = ST_IDLE;
            s_d.sclk  = mode_i.cpol;
            s_d.busy  = 1'b0;
            s_d.armed = 1'b0;
        end else begin
            if (s_q.st == ST_IDLE)
                s_d.sclk = mode_i.cpol;
            if (s_q.st == ST_SHIFT && tick_i) begin
                s_d.sclk   = ~s_q.sclk;
                s_d.busy   = 1'b1;
                s_d.edge_n = s_q.edge_n + EDGE_W'(1);
                s_d.rx_sr  = rx_next;
                if (!sample && s_q.edge_n != LAST_EDGE) begin
                    s_d.mosi  = s_q.tx_sr[WORD_W-1];
                    s_d.tx_sr = s_q.tx_sr << 1;
                end
                if (s_q.edge_n == LAST_EDGE) begin
                    s_d.rx_data  = rx_next;
                    s_d.rx_valid = 1'b1;
                    if (!can_go) begin
                        s_d.st    = ST_IDLE;
                        s_d.busy  = 1'b0;
                        s_d.armed = 1'b0;
                    end
                end
            end
            // pull the next word when idle or right after a word's last edge
            if (can_go && (s_q.st == ST_IDLE ||
                           (tick_i && s_q.edge_n == LAST_EDGE))) begin
                tx_ready_o = 1'b1;
                restart_o  = 1'b1;
                s_d.st     = ST_SHIFT;
                s_d.edge_n = '0;
                s_d.sclk   = mode_i.cpol;
                if (!mode_i.cpha) begin
                    s_d.mosi  = tx_data_i[WORD_W-1];
                    s_d.tx_sr = tx_data_i << 1;
                end else begin
                    s_d.tx_sr = tx_data_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st       <= ST_IDLE;
            s_q.sclk     <= 1'b0;
            s_q.mosi     <= 1'b0;
            s_q.busy     <= 1'b0;
            s_q.armed    <= 1'b0;
            s_q.edge_n   <= '0;
            s_q.tx_sr    <= '0;
            s_q.rx_sr    <= '0;
            s_q.rx_data  <= '0;
            s_q.rx_valid <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_o      = (s_q.st == ST_SHIFT) && en_i;
    assign sclk_o     = s_q.sclk;
    assign mosi_o     = s_q.mosi;
    assign busy_o     = s_q.busy;
    assign armed_o    = s_q.armed;
    assign rx_data_o  = s_q.rx_data;
    assign rx_valid_o = s_q.rx_valid;

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic [WORD_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              busy_o
);

    logic  en_q;
    mode_t mode_l;
    logic  tick;
    logic  run;
    logic  restart;
    logic  armed_w;
    logic  unused_cfg;

    assign unused_cfg = ^cfg_i[CB_MAN_EN-1:CB_DIV_LO+DIV_W];

    spi_cfg_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (cfg_i[CB_EN]),
        .cpol_i (cfg_i[CB_CPOL]),
        .cpha_i (cfg_i[CB_CPHA]),
        .div_i  (cfg_i[CB_DIV_LO +: DIV_W]),
        .en_o   (en_q),
        .mode_o (mode_l)
    );

    spi_clk_div u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .restart_i (restart),
        .div_i     (mode_l.div),
        .tick_o    (tick)
    );

    spi_shifter #(.WORD_W(WORD_W)) u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_q),
        .mode_i     (mode_l),
        .tick_i     (tick),
        .man_en_i   (cfg_i[CB_MAN_EN]),
        .trig_i     (cfg_i[CB_TRIG]),
        .tx_data_i  (tx_data_i),
        .tx_valid_i (tx_valid_i),
        .tx_ready_o (tx_ready_o),
        .rx_data_o  (rx_data_o),
        .rx_valid_o (rx_valid_o),
        .miso_i     (miso_i),
        .sclk_o     (sclk_o),
        .mosi_o     (mosi_o),
        .busy_o     (busy_o),
        .run_o      (run),
        .restart_o  (restart),
        .armed_o    (armed_w)
    );

endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk
    import spi_eng_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_i,
    input logic             tx_ready_o,
    input logic             rx_valid_o,
    input logic             sclk_o,
    input logic             busy_o,
    input logic             en_q,
    input logic             cpol_l,
    input logic             cpha_l,
    input logic [DIV_W-1:0] div_l,
    input logic             armed
);

    assert_div_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_l != '0);

    assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (sclk_o == $past(cpol_l)));

    assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q)) |-> ($stable(cpol_l) && $stable(cpha_l) && $stable(div_l)));

    assert_rx_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    assert_pull_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |=> !tx_ready_o);

    assert_manual_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[CB_MAN_EN] && !armed) |-> !tx_ready_o);

    assert_busy_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !busy_o);

endmodule

bind spi_shift_engine spi_shift_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_i      (cfg_i),
    .tx_ready_o (tx_ready_o),
    .rx_valid_o (rx_valid_o),
    .sclk_o     (sclk_o),
    .busy_o     (busy_o),
    .en_q       (en_q),
    .cpol_l     (mode_l.cpol),
    .cpha_l     (mode_l.cpha),
    .div_l      (mode_l.div),
    .armed      (armed_w)
);

// File: tb/spi_shift_engine_test.sv
module spi_shift_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] cfg = '0;
    logic [7:0]  tx_data_i = '0;
    logic        tx_valid_i = 1'b0;
    logic        tx_ready_o;
    logic [7:0]  rx_data_o;
    logic        rx_valid_o;
    logic        sclk_o;
    logic        mosi_o;
    logic        miso_i = 1'b0;
    logic        busy_o;

    always #4 clk = ~clk;

    spi_shift_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg),
        .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
        .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .busy_o(busy_o)
    );

    logic [7:0] txq[$];
    logic [7:0] exp_mosi[$];
    logic [7:0] slave_q[$];
    logic [7:0] exp_rx[$];

    int   n_cmp = 0, n_bad = 0;
    int   cyc = 0, last_edge = 0, ec = 0, edge_total = 0, exp_half = 2;
    bit   cpha_b = 1'b0, ign = 1'b1, pend = 1'b0;
    logic prev_sclk = 1'b0;
    logic [7:0] mosi_acc = '0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [16:0] mk(input bit en, input bit pol, input bit pha,
                                       input int dv, input bit man, input bit trig);
        logic [16:0] c;
        c = '0;
        c[0] = en; c[1] = pol; c[2] = pha; c[5:3] = 3'(dv); c[15] = man; c[16] = trig;
        return c;
    endfunction

    // driver: one item into the queue and the expected lists
    task automatic send(input logic [7:0] m, input logic [7:0] s);
        txq.push_back(m);
        exp_mosi.push_back(m);
        slave_q.push_back(s);
        exp_rx.push_back(s);
    endtask

    // transmit queue model, updated away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (pend && txq.size() != 0) void'(txq.pop_front());
            tx_valid_i = (txq.size() != 0);
            tx_data_i  = (txq.size() != 0) ? txq[0] : 8'h00;
            #1;
            pend = tx_ready_o && tx_valid_i;
        end
    end

    // monitor: slave model, edge timing and receive scoreboard
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (ign) begin
                ec = 0;
            end else if (sclk_o !== prev_sclk) begin
                if (ec != 0)
                    check((cyc - last_edge) == exp_half, "R2 half period", cyc - last_edge, exp_half);
                if (((ec % 2) == 0) ^ cpha_b)
                    mosi_acc = {mosi_acc[6:0], mosi_o};
                ec++;
                edge_total++;
                last_edge = cyc;
                if (ec == 16) begin
                    if (exp_mosi.size() != 0)
                        check(mosi_acc == exp_mosi[0], cpha_b ? "R6 mosi byte" : "R5 mosi byte",
                              mosi_acc, exp_mosi[0]);
                    else
                        check(1'b0, "R7 unexpected word", mosi_acc, 0);
                    if (exp_mosi.size() != 0) void'(exp_mosi.pop_front());
                    if (slave_q.size() != 0) void'(slave_q.pop_front());
                    ec = 0;
                end
            end
            prev_sclk = sclk_o;
            if (rst_n && rx_valid_o) begin
                if (exp_rx.size() != 0) begin
                    check(rx_data_o == exp_rx[0], "R7 rx byte", rx_data_o, exp_rx[0]);
                    void'(exp_rx.pop_front());
                end else begin
                    check(1'b0, "R7 unexpected rx push", rx_data_o, 0);
                end
            end
            miso_i = (slave_q.size() != 0) ? slave_q[0][7 - ec/2] : 1'b0;
        end
    end

    // watchdog
    initial begin
        wait (cyc > 150000);
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic configure(input bit pol, input bit pha, input int dv, input bit man);
        @(negedge clk);
        ign = 1'b1;
        cfg = mk(0, pol, pha, dv, man, 0);
        repeat (3) @(negedge clk);
        cfg = mk(1, pol, pha, dv, man, 0);
        cpha_b = pha;
        exp_half = 1 << ((dv == 0) ? 1 : dv);
        repeat (3) @(negedge clk);
        ign = 1'b0;
        check(sclk_o == pol, "R3 idle level", sclk_o, pol);
    endtask

    task automatic wait_done();
        while (exp_rx.size() != 0 || exp_mosi.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    int base;

    initial begin
        repeat (3) @(negedge clk);
        check(sclk_o == 1'b0, "R1 reset sclk", sclk_o, 0);
        check(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
        check(rx_valid_o == 1'b0 && tx_ready_o == 1'b0, "R1 reset strobes", rx_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        prev_sclk = sclk_o;

        // mode 0, code 0 captured as 1 (half period 2), back-to-back burst
        configure(0, 0, 0, 0);
        check(busy_o == 1'b0, "R10 busy before first edge", busy_o, 0);
        base = edge_total;
        send(8'hA5, 8'h3C); send(8'h01, 8'hF0); send(8'h80, 8'h5A);
        while (ec < 6) @(negedge clk);
        check(busy_o == 1'b1, "R10 busy mid burst", busy_o, 1);
        wait_done();
        check(busy_o == 1'b0, "R10 busy after burst", busy_o, 0);
        check(edge_total - base == 48, "R7 edge count", edge_total - base, 48);
        check(txq.size() == 0, "R8 queue drained", txq.size(), 0);

        // mode 1, divisor 3
        configure(0, 1, 3, 0);
        base = edge_total;
        send(8'hC3, 8'h96); send(8'h7E, 8'h01);
        wait_done();
        check(edge_total - base == 32, "R7 edge count mode1", edge_total - base, 32);
        check(sclk_o == 1'b0, "R3 rest after mode1", sclk_o, 0);

        // mode 2, divisor 2
        configure(1, 0, 2, 0);
        send(8'h5A, 8'hE7); send(8'hFF, 8'h00);
        wait_done();
        check(sclk_o == 1'b1, "R3 rest after mode2", sclk_o, 1);

        // mode 3, divisor 7
        configure(1, 1, 7, 0);
        send(8'h69, 8'hB4);
        wait_done();

        // R4: rewrite settings while enabled; old ones stay in force
        configure(1, 1, 1, 0);
        @(negedge clk);
        cfg = mk(1, 0, 0, 5, 0, 0);
        repeat (6) @(negedge clk);
        check(sclk_o == 1'b1, "R4 level kept", sclk_o, 1);
        send(8'h2D, 8'hD2);
        wait_done();
        check(sclk_o == 1'b1, "R4 level after word", sclk_o, 1);

        // R9 manual start
        configure(0, 0, 1, 1);
        base = edge_total;
        send(8'h11, 8'h88); send(8'h42, 8'h24);
        repeat (300) @(negedge clk);
        check(txq.size() == 2, "R9 held before trigger", txq.size(), 2);
        check(edge_total == base, "R9 no edges before trigger", edge_total - base, 0);
        cfg = mk(1, 0, 0, 1, 1, 1);
        @(negedge clk);
        cfg = mk(1, 0, 0, 1, 1, 0);
        wait_done();
        check(txq.size() == 0, "R9 drained after trigger", txq.size(), 0);
        check(edge_total - base == 32, "R9 edges after trigger", edge_total - base, 32);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule